// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a 32-bit address space with a configurable number of programmable regions. Software sets each region up through a 32-bit word register port. A region has a base and a limit, both aligned to 32-byte blocks, a two-bit permission code, a no-execute flag, an enable and a three-bit index. The index picks one of eight attribute bytes, which sit in two packed attribute words. A global control word switches the unit on and enables a background fallback for privileged accesses.

On the check side, each bus access gives an address, a privilege flag, a write flag and an instruction-fetch flag. The block answers in the same cycle with allow or fault, and with the attribute byte of the region that matched. The unit starts disabled, and in that state it allows everything. The base and limit windows act on the region named by the region-number register. Three alias windows reach the neighbouring regions of an aligned group of four, so four regions can be programmed without rewriting the number register.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset the unit is disabled, the control and region-number registers read 0, and every region reads 0 and is disabled. While the unit is disabled, every access is allowed with an attribute byte of 0.
- R2: Offset 0xD90 reads the region count in bits [15:8] and 0 elsewhere. Offset 0xDBC and unmapped offsets read 0. Register reads return data one clock after the offset is presented.
- R3: A write to a base window (0xD9C, 0xDA4, 0xDAC, 0xDB4) stores address bits [31:5], the permission code from bits [2:1] and the no-execute flag from bit 0, and drops bits [4:3]. A write to a limit window (0xDA0, 0xDA8, 0xDB0, 0xDB8) stores bits [31:5], the attribute index from bits [3:1] and the enable from bit 0, and drops bit 4. A read returns the stored fields in the same positions.
- R4: An access matches an enabled region when its address bits [31:5] lie between the stored base and limit, both ends included. The limit therefore covers its whole last 32-byte block.
- R5: The permission codes are 0 = read/write privileged only, 1 = read/write any level, 2 = read-only privileged only, 3 = read-only any level. A write to a read-only region faults, and an unprivileged access to a privileged-only region faults.
- R6: An instruction fetch from a region whose no-execute flag is 1 faults. A fetch from a region whose flag is 0 is not restricted by this rule.
- R7: When exactly one enabled region matches, the attribute output is byte (index mod 4) of the first attribute word (0xDC0) for indices 0–3, and of the second word (0xDC4) for indices 4–7. Byte 0 is bits [7:0]. Otherwise the attribute output is 0.
- R8: When the unit is enabled and no enabled region matches, a privileged access is allowed only if the background bit is set. An unprivileged access always faults.
- R9: An access that matches two or more enabled regions faults.
- R10: Alias window k (k = 1, 2, 3 at 0xDA4/0xDA8, 0xDAC/0xDB0, 0xDB4/0xDB8) acts on the region whose number is the region-number register with its low two bits replaced by k. The plain window acts on the number itself.
- R11: In the control register at 0xD94, bit 0 enables the unit and bit 2 enables the background fallback. All other control bits read 0. The region-number register sits at 0xD98. A region whose enable is 0 never matches.
- R12: The check result is combinational from the access inputs. A configuration write becomes visible to accesses from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_addr |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_allow | output | 1 | 1 = allowed, 0 = fault |
| acc_attr | output | 8 | Attribute byte of the single matching region |

## Verification
The check outputs are combinational. The bench presents an access away from the clock edge and samples allow and attribute one time unit later, within the same cycle. Read data is registered, so a read presents the offset at a falling edge and samples one unit after the next rising edge. Configuration writes are driven at a falling edge and take effect at the following rising edge. Every access after a write is therefore issued at least half a cycle later, which keeps each comparison against the bench's shadow model on the correct side of the update.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;
  localparam int unsigned GRAN_LSB = 5;
  localparam int unsigned BLK_W    = 32 - GRAN_LSB;
  localparam int unsigned OFF_W    = 12;

  localparam logic [OFF_W-1:0] OFF_TYPE    = 12'hD90;
  localparam logic [OFF_W-1:0] OFF_CTRL    = 12'hD94;
  localparam logic [OFF_W-1:0] OFF_RNUM    = 12'hD98;
  localparam logic [OFF_W-1:0] OFF_BASE    = 12'hD9C;
  localparam logic [OFF_W-1:0] OFF_LIMIT   = 12'hDA0;
  localparam logic [OFF_W-1:0] OFF_BASE_1  = 12'hDA4;
  localparam logic [OFF_W-1:0] OFF_LIMIT_1 = 12'hDA8;
  localparam logic [OFF_W-1:0] OFF_BASE_2  = 12'hDAC;
  localparam logic [OFF_W-1:0] OFF_LIMIT_2 = 12'hDB0;
  localparam logic [OFF_W-1:0] OFF_BASE_3  = 12'hDB4;
  localparam logic [OFF_W-1:0] OFF_LIMIT_3 = 12'hDB8;
  localparam logic [OFF_W-1:0] OFF_ATTRW0  = 12'hDC0;
  localparam logic [OFF_W-1:0] OFF_ATTRW1  = 12'hDC4;

  // bit 1 = read-only, bit 0 = any privilege level
  typedef enum logic [1:0] {
    PERM_RW_PRIV = 2'd0,
    PERM_RW_ANY  = 2'd1,
    PERM_RO_PRIV = 2'd2,
    PERM_RO_ANY  = 2'd3
  } perm_e;

  typedef struct packed {
    logic [BLK_W-1:0] base;
    logic [BLK_W-1:0] limit;
    perm_e            perm;
    logic             no_exec;
    logic             en;
    logic [2:0]       attr_idx;
  } region_t;
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [OFF_W-1:0]                  cfg_addr,
  input  logic [31:0]                       cfg_wdata,
  output logic [31:0]                       cfg_rdata,
  output region_t [NUM_REGIONS-1:0]         regions_o,
  output logic [1:0][31:0]                  attr_words_o,
  output logic                              unit_en_o,
  output logic                              bg_en_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS);

  region_t [NUM_REGIONS-1:0] regs_q;
  logic [1:0][31:0]          attrw_q;
  logic [IDX_W-1:0]          rnum_q;
  logic                      en_q, bg_q;

  logic             hit_base, hit_limit, alias_on;
  logic [1:0]       alias_k;
  logic [IDX_W-1:0] tgt;
  logic [31:0]      rd_d;

  always_comb begin
    hit_base  = 1'b0;
    hit_limit = 1'b0;
    alias_on  = 1'b0;
    alias_k   = 2'd0;
    case (cfg_addr)
      OFF_BASE:    hit_base = 1'b1;
      OFF_LIMIT:   hit_limit = 1'b1;
      OFF_BASE_1:  begin hit_base  = 1'b1; alias_on = 1'b1; alias_k = 2'd1; end
      OFF_LIMIT_1: begin hit_limit = 1'b1; alias_on = 1'b1; alias_k = 2'd1; end
      OFF_BASE_2:  begin hit_base  = 1'b1; alias_on = 1'b1; alias_k = 2'd2; end
      OFF_LIMIT_2: begin hit_limit = 1'b1; alias_on = 1'b1; alias_k = 2'd2; end
      OFF_BASE_3:  begin hit_base  = 1'b1; alias_on = 1'b1; alias_k = 2'd3; end
      OFF_LIMIT_3: begin hit_limit = 1'b1; alias_on = 1'b1; alias_k = 2'd3; end
      default: ;
    endcase
    tgt = alias_on ? ((rnum_q & ~IDX_W'(3)) | IDX_W'(alias_k)) : rnum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q  <= '0;
      attrw_q <= '0;
      rnum_q  <= '0;
      en_q    <= 1'b0;
      bg_q    <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_CTRL:   begin en_q <= cfg_wdata[0]; bg_q <= cfg_wdata[2]; end
        OFF_RNUM:   rnum_q <= cfg_wdata[IDX_W-1:0];
        OFF_ATTRW0: attrw_q[0] <= cfg_wdata;
        OFF_ATTRW1: attrw_q[1] <= cfg_wdata;
        default: ;
      endcase
      if (hit_base) begin
        regs_q[tgt].base    <= cfg_wdata[31:GRAN_LSB];
        regs_q[tgt].perm    <= perm_e'(cfg_wdata[2:1]);
        regs_q[tgt].no_exec <= cfg_wdata[0];
      end
      if (hit_limit) begin
        regs_q[tgt].limit    <= cfg_wdata[31:GRAN_LSB];
        regs_q[tgt].attr_idx <= cfg_wdata[3:1];
        regs_q[tgt].en       <= cfg_wdata[0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (cfg_addr)
      OFF_TYPE:   rd_d = 32'(NUM_REGIONS) << 8;
      OFF_CTRL:   rd_d = {29'd0, bg_q, 1'b0, en_q};
      OFF_RNUM:   rd_d = 32'(rnum_q);
      OFF_ATTRW0: rd_d = attrw_q[0];
      OFF_ATTRW1: rd_d = attrw_q[1];
      default: ;
    endcase
    if (hit_base)
      rd_d = {regs_q[tgt].base, {(GRAN_LSB-3){1'b0}}, regs_q[tgt].perm, regs_q[tgt].no_exec};
    if (hit_limit)
      rd_d = {regs_q[tgt].limit, {(GRAN_LSB-4){1'b0}}, regs_q[tgt].attr_idx, regs_q[tgt].en};
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_d;
  end

  assign regions_o    = regs_q;
  assign attr_words_o = attrw_q;
  assign unit_en_o    = en_q;
  assign bg_en_o      = bg_q;

  // R11: a control write lands in the enable bits on the next edge
  assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == OFF_CTRL) |=> (unit_en_o == $past(cfg_wdata[0]) && bg_en_o == $past(cfg_wdata[2])));
  // R1: first cycle out of reset shows a disabled unit
  assert_reset_off_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!unit_en_o && !bg_en_o));
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  region_t [NUM_REGIONS-1:0] regions_i,
  input  logic [BLK_W-1:0]          blk_i,
  output logic [NUM_REGIONS-1:0]    hit_o
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic above_base, below_limit;
    assign above_base  = (blk_i >= regions_i[g].base);
    assign below_limit = (blk_i <= regions_i[g].limit);
    assign hit_o[g]    = regions_i[g].en && above_base && below_limit;
  end
endmodule

// File: rtl/mpu_access_eval.sv
module mpu_access_eval
  import mpu_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  region_t [NUM_REGIONS-1:0] regions_i,
  input  logic [NUM_REGIONS-1:0]    hit_i,
  input  logic [1:0][31:0]          attr_words_i,
  input  logic                      unit_en_i,
  input  logic                      bg_en_i,
  input  logic                      priv_i,
  input  logic                      write_i,
  input  logic                      fetch_i,
  output logic                      allow_o,
  output logic [7:0]                attr_o
);
  region_t    sel;
  logic       none_hit, one_hit;
  logic       perm_ok, exec_ok;
  logic [4:0] byte_lsb;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (hit_i[i]) sel = region_t'(sel | regions_i[i]);
  end

  assign none_hit = (hit_i == '0);
  assign one_hit  = ($countones(hit_i) == 1);
  assign perm_ok  = !(write_i && sel.perm[1]) && (priv_i || sel.perm[0]);
  assign exec_ok  = !(fetch_i && sel.no_exec);
  assign byte_lsb = {sel.attr_idx[1:0], 3'b000};

  always_comb begin
    allow_o = 1'b0;
    attr_o  = 8'h00;
    if (!unit_en_i) begin
      allow_o = 1'b1;
    end else if (none_hit) begin
      allow_o = priv_i && bg_en_i;
    end else if (one_hit) begin
      allow_o = perm_ok && exec_ok;
      attr_o  = attr_words_i[sel.attr_idx[2]][byte_lsb +: 8];
    end
  end

  assert_off_allows_R1: assert property (@(posedge clk) disable iff (rst)
    !unit_en_i |-> (allow_o && attr_o == 8'h00));
  assert_overlap_faults_R9: assert property (@(posedge clk) disable iff (rst)
    (unit_en_i && $countones(hit_i) > 1) |-> (!allow_o && attr_o == 8'h00));
  assert_unpriv_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (unit_en_i && hit_i == '0 && !priv_i) |-> !allow_o);
  assert_ro_write_R5: assert property (@(posedge clk) disable iff (rst)
    (unit_en_i && $countones(hit_i) == 1 && write_i && sel.perm[1]) |-> !allow_o);
  assert_fetch_nx_R6: assert property (@(posedge clk) disable iff (rst)
    (unit_en_i && $countones(hit_i) == 1 && fetch_i && sel.no_exec) |-> !allow_o);
endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] acc_addr,
  input  logic        acc_priv,
  input  logic        acc_write,
  input  logic        acc_fetch,
  output logic        acc_allow,
  output logic [7:0]  acc_attr
);
  region_t [NUM_REGIONS-1:0] regions;
  logic [1:0][31:0]          attr_words;
  logic                      unit_en, bg_en;
  logic [NUM_REGIONS-1:0]    hit;

  mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .regions_o(regions),
    .attr_words_o(attr_words), .unit_en_o(unit_en), .bg_en_o(bg_en)
  );

  mpu_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .regions_i(regions), .blk_i(acc_addr[31:GRAN_LSB]), .hit_o(hit)
  );

  mpu_access_eval #(.NUM_REGIONS(NUM_REGIONS)) u_eval (
    .clk(clk), .rst(rst), .regions_i(regions), .hit_i(hit),
    .attr_words_i(attr_words), .unit_en_i(unit_en), .bg_en_i(bg_en),
    .priv_i(acc_priv), .write_i(acc_write), .fetch_i(acc_fetch),
    .allow_o(acc_allow), .attr_o(acc_attr)
  );

  // R11: a disabled region never reports a hit
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
    assert_off_region_nohit_R11: assert property (@(posedge clk) disable iff (rst)
      !regions[g].en |-> !hit[g]);
  end
endmodule

// File: tb/sim_mpu_region_guard.sv
module sim_mpu_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = 12'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_priv = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
  logic        acc_allow;
  logic [7:0]  acc_attr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [26:0] sh_base [NREG];
  logic [26:0] sh_lim  [NREG];
  logic [1:0]  sh_perm [NREG];
  logic        sh_nx   [NREG];
  logic        sh_ren  [NREG];
  logic [2:0]  sh_aidx [NREG];
  logic [31:0] sh_aw   [2];
  logic        sh_en = 0, sh_bg = 0;
  logic [2:0]  sh_rnum = 0;

  mpu_region_guard #(.NUM_REGIONS(NREG)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_allow(acc_allow), .acc_attr(acc_attr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic shadow_clear();
    for (int i = 0; i < NREG; i++) begin
      sh_base[i] = 0; sh_lim[i] = 0; sh_perm[i] = 0;
      sh_nx[i] = 0; sh_ren[i] = 0; sh_aidx[i] = 0;
    end
    sh_aw[0] = 0; sh_aw[1] = 0; sh_en = 0; sh_bg = 0; sh_rnum = 0;
  endtask

  task automatic reg_wr(logic [11:0] off, logic [31:0] d);
    logic [2:0] t;
    int k;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    k = -1;
    case (off)
      12'hD94: begin sh_en = d[0]; sh_bg = d[2]; end
      12'hD98: sh_rnum = d[2:0];
      12'hDC0: sh_aw[0] = d;
      12'hDC4: sh_aw[1] = d;
      12'hD9C, 12'hDA0: k = 0;
      12'hDA4, 12'hDA8: k = 1;
      12'hDAC, 12'hDB0: k = 2;
      12'hDB4, 12'hDB8: k = 3;
      default: ;
    endcase
    if (k >= 0) begin
      t = (k == 0) ? sh_rnum : {sh_rnum[2], 2'(k)};
      if (off == 12'hD9C || off == 12'hDA4 || off == 12'hDAC || off == 12'hDB4) begin
        sh_base[t] = d[31:5]; sh_perm[t] = d[2:1]; sh_nx[t] = d[0];
      end else begin
        sh_lim[t] = d[31:5]; sh_aidx[t] = d[3:1]; sh_ren[t] = d[0];
      end
    end
  endtask

  task automatic reg_rd(logic [11:0] off, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = off;
    @(posedge clk);
    #1 d = cfg_rdata;
  endtask

  function automatic logic [8:0] model(logic [31:0] a, logic p, logic w, logic f);
    int cnt = 0;
    int idx = 0;
    logic ok;
    if (!sh_en) return {1'b1, 8'h00};
    for (int i = 0; i < NREG; i++)
      if (sh_ren[i] && a[31:5] >= sh_base[i] && a[31:5] <= sh_lim[i]) begin
        cnt++; idx = i;
      end
    if (cnt == 0) return {p && sh_bg, 8'h00};
    if (cnt > 1) return 9'h000;
    ok = !(w && sh_perm[idx][1]) && (p || sh_perm[idx][0]) && !(f && sh_nx[idx]);
    return {ok, sh_aw[sh_aidx[idx][2]][8*sh_aidx[idx][1:0] +: 8]};
  endfunction

  task automatic access(string req, logic [31:0] a, logic p, logic w, logic f);
    logic [8:0] e;
    @(negedge clk);
    acc_addr = a; acc_priv = p; acc_write = w; acc_fetch = f;
    #1;
    e = model(a, p, w, f);
    chk(req, {23'd0, acc_allow, acc_attr}, {23'd0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd2024));
    shadow_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    reg_rd(12'hD94, rd); chk("R1 ctrl", rd, 32'h0);
    reg_rd(12'hD98, rd); chk("R1 rnum", rd, 32'h0);
    reg_rd(12'hDA0, rd); chk("R1 region0 limit", rd, 32'h0);
    access("R1 disabled allows", 32'h2000_0000, 1'b0, 1'b1, 1'b1);
    // R2: type and reserved
    reg_rd(12'hD90, rd); chk("R2 type", rd, 32'(NREG) << 8);
    reg_rd(12'hDBC, rd); chk("R2 reserved", rd, 32'h0);

    // R3: region 1 programming with dropped low bits
    reg_wr(12'hD98, 32'd1);
    reg_wr(12'hD9C, 32'h2000_001F);
    reg_wr(12'hDA0, 32'h2000_03FB);
    reg_rd(12'hD9C, rd); chk("R3 base readback", rd, 32'h2000_0007);
    reg_rd(12'hDA0, rd); chk("R3 limit readback", rd, 32'h2000_03EB);
    reg_wr(12'hDC0, 32'h1122_3344);
    reg_wr(12'hDC4, 32'hAABB_CCDD);
    reg_wr(12'hD94, 32'h1);

    access("R4 R7 limit block inclusive", 32'h2000_03FF, 1'b1, 1'b0, 1'b0);
    chk("R7 attr index 5", {24'd0, acc_attr}, 32'hCC);
    access("R4 below base", 32'h1FFF_FFE0, 1'b1, 1'b0, 1'b0);
    access("R5 RO any unpriv read", 32'h2000_0000, 1'b0, 1'b0, 1'b0);
    access("R5 RO write", 32'h2000_0000, 1'b1, 1'b1, 1'b0);
    chk("R5 RO write faults", {31'd0, acc_allow}, 32'h0);
    access("R6 no-exec fetch", 32'h2000_0040, 1'b1, 1'b0, 1'b1);
    chk("R6 fetch faults", {31'd0, acc_allow}, 32'h0);
    access("R8 miss no background", 32'h2000_0400, 1'b1, 1'b0, 1'b0);
    chk("R8 miss faults", {31'd0, acc_allow}, 32'h0);

    // R11: control readback masks unused bit
    reg_wr(12'hD94, 32'h7);
    reg_rd(12'hD94, rd); chk("R11 ctrl readback", rd, 32'h5);
    access("R8 background priv", 32'h2000_0400, 1'b1, 1'b0, 1'b0);
    chk("R8 background allows", {31'd0, acc_allow}, 32'h1);
    access("R8 background unpriv", 32'h2000_0400, 1'b0, 1'b0, 1'b0);

    // R10: alias pair 2 with number 5 reaches region 6
    reg_wr(12'hD98, 32'd5);
    reg_wr(12'hDAC, 32'h2000_0102);
    reg_wr(12'hDB0, 32'h2000_0111);
    reg_rd(12'hD9C, rd); chk("R10 region5 untouched", rd, 32'h0);
    reg_wr(12'hD98, 32'd6);
    reg_rd(12'hD9C, rd); chk("R10 region6 base", rd, 32'h2000_0102);
    reg_rd(12'hDA0, rd); chk("R10 region6 limit", rd, 32'h2000_0101);

    access("R9 overlap", 32'h2000_0110, 1'b1, 1'b0, 1'b0);
    chk("R9 overlap faults", {31'd0, acc_allow}, 32'h0);

    // R11/R12: disable region 1; next access sees it gone
    reg_wr(12'hD98, 32'd1);
    reg_wr(12'hDA0, 32'h2000_03EA);
    access("R11 R12 disabled region ignored", 32'h2000_0110, 1'b0, 1'b1, 1'b1);
    chk("R12 attr index 0", {23'd0, acc_allow, acc_attr}, 32'h144);

    // randomized rounds
    for (int rnd = 0; rnd < 6; rnd++) begin
      for (int r = 0; r < NREG; r++) begin
        logic [31:0] b, l;
        logic [11:0] bo, lo;
        b = 32'h2000_0000 + (($urandom % 64) << 5) + ($urandom % 32);
        l = 32'h2000_0000 + ((b[31:5] - 27'h100_0000 + $urandom % 16) << 5) + ($urandom % 32);
        l[0] = ($urandom % 4) != 0;
        if ($urandom % 2) begin
          reg_wr(12'hD98, 32'(r));
          bo = 12'hD9C; lo = 12'hDA0;
        end else begin
          reg_wr(12'hD98, 32'(r & 4));
          bo = 12'hD9C + 12'(8 * (r % 4)); lo = bo + 12'h4;
        end
        reg_wr(bo, b);
        reg_wr(lo, l);
      end
      reg_wr(12'hDC0, $urandom);
      reg_wr(12'hDC4, $urandom);
      reg_wr(12'hD94, {29'd0, 1'($urandom % 2), 1'b0, 1'(($urandom % 5) != 0)});
      for (int n = 0; n < 300; n++)
        access("R4 R5 R6 R7 R8 R9 random", 32'h2000_0000 + ($urandom % 32'hA00) - 32'h40,
               1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule